// File: doc/BRIEF.md
# Masked Time-Match Alarm Interrupt Unit

This block watches a running BCD calendar time (day of month, hours, minutes, seconds) supplied by counters outside it. It holds four alarm bytes, one per field. On every one-second tick it compares the time with those bytes. When all four agree, it sets a sticky alarm flag. A field whose alarm byte has bit 7 set is treated as a wildcard and always agrees. Loading all four bytes with a wildcard therefore gives a plain once-per-second event.

The host reaches the block through a small byte-wide register port. Reading the status register returns the flag and clears it as a side effect. An enable register gates the flag onto an active-low interrupt pin. Software can tell a per-second event from a true alarm by reading back bit 7 of the seconds alarm byte. All pins are plain control and status signals: there is no streamed data, so no valid/ready handshake is used.

Top module: `alm_match_irq`

## Requirements
- R1: After reset, the status register (address 0) reads 0x00, the enable register (address 5) reads 0x00, all four alarm bytes read 0x80, and `irq_n` is high.
- R2: A write to address 1, 2, 3 or 4 stores the whole byte as the seconds, minutes, hours or date alarm respectively, and a read of that address returns it.
- R3: When `sec_tick` is high and each unmasked alarm byte equals the matching time byte in bits 6:0, status bit 6 reads 1 from the next cycle on. Bit 7 of the time inputs is not compared.
- R4: The comparison happens only in cycles with `sec_tick` high. A matching time with no tick leaves the flag at 0.
- R5: A difference in bits 6:0 of any single unmasked field keeps the flag at 0 on a tick.
- R6: An alarm byte with bit 7 set matches any value of its time field.
- R7: With all four alarm bytes masked, every tick sets the flag.
- R8: A read of address 0 returns the flag in bit 6, with all other bits 0. From the next cycle the flag is 0.
- R9: If a setting tick and a status read fall in the same cycle, that read returns the old flag, and the flag is 1 afterwards.
- R10: Enable register bit 6 is the only stored enable bit, and the other bits read 0. `irq_n` is low exactly while both the flag and enable bit 6 are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse after the time counters have advanced |
| cur_sec | input | 8 | BCD seconds |
| cur_min | input | 8 | BCD minutes |
| cur_hour | input | 8 | BCD hours |
| cur_date | input | 8 | BCD day of month |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears the flag when addressing 0) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
A wrong comparator or mask decode shows up as a status bit 6 that differs from the expected value one cycle after the tick. It can then be read in the very next bus read. A flag that sets without a tick, or fails to clear, is caught by the following status read. An enable register or interrupt gate that is wrong shows on `irq_n` in the same cycle the flag or enable changes. The vector table varies one field at a time so that each comparator lane is checked on its own.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int BYTE_W     = 8;
  localparam int REG_AW     = 3;
  localparam int FIELD_CNT  = 4;
  localparam int WILD_BIT   = 7;
  localparam int FLAG_BIT   = 6;
  localparam int IEN_BIT    = 6;
  localparam logic [REG_AW-1:0] A_STATUS = 3'd0;
  localparam logic [REG_AW-1:0] A_ALM0   = 3'd1;
  localparam logic [REG_AW-1:0] A_IEN    = 3'd5;
  // field index: 0 seconds, 1 minutes, 2 hours, 3 date
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] alarm_val,
  input  logic [W-1:0] cur_val,
  output logic         hit
);
  localparam logic [W-1:0] CMP_MASK = {1'b0, {(W-1){1'b1}}};
  logic eq;
  assign eq  = ((alarm_val ^ cur_val) & CMP_MASK) == '0;
  assign hit = alarm_val[W-1] | eq;
endmodule

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int N  = FIELD_CNT,
  parameter int AW = REG_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] alarm_o,
  output logic                ien_o
);
  localparam logic [W-1:0] WILD_RST = W'(1) << (W-1);

  for (genvar g = 0; g < N; g++) begin : g_alm
    localparam logic [AW-1:0] MY_ADDR = AW'(int'(A_ALM0) + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          alarm_o[g] <= WILD_RST;
      else if (wr_en && addr == MY_ADDR)   alarm_o[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ien_o <= 1'b0;
    else if (wr_en && addr == A_IEN) ien_o <= wdata[IEN_BIT];
  end
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic all_hit,
  input  logic clr_req,
  output logic flag_q
);
  logic set_ev;
  assign set_ev = sec_tick & all_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_ev)  flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  // R3
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && all_hit) |=> flag_q);
  // R4
  no_tick_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(flag_q));
  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !(sec_tick && all_hit)) |=> !flag_q);
  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && sec_tick && all_hit) |=> flag_q);
endmodule

// File: rtl/alm_match_irq.sv
module alm_match_irq
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [BYTE_W-1:0] cur_sec,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [BYTE_W-1:0] cur_hour,
  input  logic [BYTE_W-1:0] cur_date,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq_n
);
  logic [FIELD_CNT-1:0][BYTE_W-1:0] alarm_v;
  logic [FIELD_CNT-1:0][BYTE_W-1:0] cur_v;
  logic [FIELD_CNT-1:0]             hit_v;
  logic ien, flag, all_hit, clr_req;

  assign cur_v = {cur_date, cur_hour, cur_min, cur_sec};

  alm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .alarm_o(alarm_v), .ien_o(ien)
  );

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_cmp
    alm_field_cmp #(.W(BYTE_W)) u_cmp (
      .alarm_val(alarm_v[g]), .cur_val(cur_v[g]), .hit(hit_v[g])
    );
  end

  assign all_hit = &hit_v;
  assign clr_req = bus_rd && (bus_addr == A_STATUS);

  alm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .all_hit(all_hit),
    .clr_req(clr_req), .flag_q(flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STATUS)   bus_rdata[FLAG_BIT] = flag;
    else if (bus_addr == A_IEN) bus_rdata[IEN_BIT]  = ien;
    else begin
      for (int i = 0; i < FIELD_CNT; i++)
        if (bus_addr == REG_AW'(int'(A_ALM0) + i)) bus_rdata = alarm_v[i];
    end
  end

  assign irq_n = ~(flag & ien);

  logic all_wild;
  always_comb begin
    all_wild = 1'b1;
    for (int i = 0; i < FIELD_CNT; i++) all_wild &= alarm_v[i][WILD_BIT];
  end

  // R7
  all_wild_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_wild && sec_tick) |=> flag);
  // R10
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> irq_n);
endmodule

// File: tb/alm_match_irq_tb.sv
module alm_match_irq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_date = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq_n;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  alm_match_irq dut_i (.*);

  typedef struct packed {
    logic [7:0] as, am, ah, ad, ts, tm, th, td;
    logic       exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h56, 8'h34, 8'h12, 8'h15, 8'h56, 8'h34, 8'h12, 8'h15, 1'b1},
    '{8'h56, 8'h34, 8'h12, 8'h15, 8'h57, 8'h34, 8'h12, 8'h15, 1'b0},
    '{8'h56, 8'h34, 8'h12, 8'h15, 8'h56, 8'h35, 8'h12, 8'h15, 1'b0},
    '{8'h56, 8'h34, 8'h12, 8'h15, 8'h56, 8'h34, 8'h22, 8'h15, 1'b0},
    '{8'h56, 8'h34, 8'h12, 8'h15, 8'h56, 8'h34, 8'h12, 8'h31, 1'b0},
    '{8'h80, 8'h34, 8'h12, 8'h15, 8'h07, 8'h34, 8'h12, 8'h15, 1'b1},
    '{8'h00, 8'h59, 8'h80, 8'h80, 8'h00, 8'h59, 8'h23, 8'h01, 1'b1},
    '{8'h80, 8'h80, 8'h80, 8'h80, 8'h41, 8'h07, 8'h19, 8'h28, 1'b1},
    '{8'h10, 8'h20, 8'h08, 8'h80, 8'h10, 8'h21, 8'h08, 8'h30, 1'b0},
    '{8'h56, 8'h34, 8'h12, 8'h15, 8'hD6, 8'h34, 8'h12, 8'h15, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic tick;
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(3'd0, rv); chk("R1 status", rv, 8'h00);
    rd(3'd5, rv); chk("R1 enable", rv, 8'h00);
    for (int i = 1; i <= 4; i++) begin rd(3'(i), rv); chk("R1 alarm", rv, 8'h80); end
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    // R2 readback of each alarm address
    for (int i = 1; i <= 4; i++) wr(3'(i), 8'hA0 + 8'(i));
    for (int i = 1; i <= 4; i++) begin rd(3'(i), rv); chk("R2 readback", rv, 8'hA0 + 8'(i)); end

    // vector table: R3 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      wr(3'd1, VECS[v].as); wr(3'd2, VECS[v].am);
      wr(3'd3, VECS[v].ah); wr(3'd4, VECS[v].ad);
      cur_sec = VECS[v].ts; cur_min = VECS[v].tm;
      cur_hour = VECS[v].th; cur_date = VECS[v].td;
      tick();
      rd(3'd0, rv);
      chk("R3/R5/R6/R7 match", rv, VECS[v].exp ? 8'h40 : 8'h00);
    end

    // R4: matching time, no tick
    wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80); wr(3'd4, 8'h80);
    repeat (5) @(negedge clk);
    rd(3'd0, rv); chk("R4 no tick", rv, 8'h00);
    // R8: read clears
    tick();
    rd(3'd0, rv); chk("R8 first read", rv, 8'h40);
    rd(3'd0, rv); chk("R8 cleared", rv, 8'h00);
    // R9: tick and read in one cycle
    @(negedge clk); sec_tick = 1; bus_rd = 1; bus_addr = 3'd0;
    #1 rv = bus_rdata;
    @(negedge clk); sec_tick = 0; bus_rd = 0;
    chk("R9 old value", rv, 8'h00);
    rd(3'd0, rv); chk("R9 set wins", rv, 8'h40);
    // R10: enable and irq
    tick();
    chk("R10 irq off w/o enable", {7'd0, irq_n}, 8'h01);
    wr(3'd5, 8'hBF);
    rd(3'd5, rv); chk("R10 only bit6", rv, 8'h00);
    chk("R10 irq still off", {7'd0, irq_n}, 8'h01);
    wr(3'd5, 8'hFF);
    rd(3'd5, rv); chk("R10 enable bit6", rv, 8'h40);
    chk("R10 irq on", {7'd0, irq_n}, 8'h00);
    rd(3'd0, rv);
    chk("R10 irq off after clear", {7'd0, irq_n}, 8'h01);
    tick();
    chk("R10 irq reasserts", {7'd0, irq_n}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule